// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This controller connects a 32-bit internal request port to an external 16-bit asynchronous static memory (SRAM, PSRAM or NOR flash). A requester presents a byte address, write data, a transfer size and a direction. The controller then runs one or two memory cycles on the external pins, driving chip select, read strobe, write strobe, an address-valid strobe, two active-low byte lanes, a halfword address and the data bus. When it finishes, it returns a one-cycle completion pulse and, for reads, the assembled read word.

Each memory cycle has three parts: a programmable address-setup phase, a programmable data phase, and one fixed hold cycle. In the plain configuration the memory type selects the strobe shape and one timing set serves both directions. In the extended configuration, reads and writes each pick one of four strobe variants and use their own timing set. The configuration is sampled when a request is accepted. All pins are registered, and no clock leaves the block.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset, and whenever `busy` is low, the pins are in their quiet state: `mem_ce_n`, `mem_oe_n`, `mem_we_n` and `mem_adv_n` are 1, `mem_bl_n` is 2'b11, and `mem_dq_oe`, `done` and `busy` are 0. Every output is a register.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. Each memory cycle then holds `mem_ce_n` low for three parts in order:
  - the setup value in cycles (0 means no setup cycles);
  - the data-phase value in cycles, with 0 treated as 1;
  - exactly one hold cycle.
- R3: On a read, `mem_oe_n` is low during the whole data phase and high during the hold cycle. The halfword on `mem_dq_in` is captured at the clock edge that ends the last data-phase cycle, which is the same edge on which `mem_oe_n` rises.
- R4: On a write:
  - `mem_we_n` is low exactly during the data phase.
  - `mem_dq_oe` is 1 during the data phase and the hold cycle, and 0 at all other times.
  - `mem_dq_out` carries the halfword for that cycle.
  - `mem_oe_n` stays high for the whole write.
- R5: `mem_bl_n` is active low. Bit 0 enables `dq[7:0]` and bit 1 enables `dq[15:8]`.
  - Size code 0 (byte) asserts only bit 0 when address bit 0 is 0, and only bit 1 when address bit 0 is 1. The byte is placed on both halves of `mem_dq_out`.
  - Size codes 1 (halfword) and 2 (word) assert both lanes.
- R6: A size-2 request runs two back-to-back memory cycles. The first uses halfword address `req_addr>>1` and data bits [15:0]; the second uses that address plus one and data bits [31:16]. `mem_ce_n` stays low between the two cycles.
- R7: After the last hold cycle there is one cycle with `mem_ce_n` high in which `done` is 1 and `busy` is still 1. After a read, `rdata` in that cycle holds:
  - for a byte read, the addressed byte, zero-extended;
  - for a halfword read, the halfword, zero-extended;
  - for a word read, `{upper, lower}`.
- R8: With `cfg_ext` at 0, memory type 0 (SRAM) or 1 (PSRAM) gives mode 1: `mem_adv_n` stays high, and a read holds `mem_oe_n` low from the start of setup. Memory type 2 (NOR) gives mode 2: `mem_adv_n` is low for the setup phase only, and `mem_oe_n` is low only in the data phase. Both directions use the read timing set.
- R9: With `cfg_ext` at 1, a read uses `cfg_rd_mode` and the read timing set, and a write uses `cfg_wr_mode` and the write timing set. The variant codes are:
  - 0: no address-valid pulse, read strobe in the data phase only;
  - 1: address-valid pulse during setup, read strobe in the data phase only;
  - 2: address-valid pulse during setup, read strobe from the start of setup;
  - 3: no address-valid pulse, read strobe from the start of setup.
- R10: While `busy` is 1, `req_valid` and changes to the configuration inputs have no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data (byte in [7:0], halfword in [15:0]) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid with done |
| cfg_ext | input | 1 | Extended (per-direction) mode select |
| cfg_mem_type | input | 2 | 0 SRAM, 1 PSRAM, 2 NOR |
| cfg_rd_mode | input | 2 | Read strobe variant (extended) |
| cfg_wr_mode | input | 2 | Write strobe variant (extended) |
| cfg_rd_addset | input | CNT_W | Read (or shared) setup cycles |
| cfg_rd_datast | input | CNT_W | Read (or shared) data cycles |
| cfg_wr_addset | input | CNT_W | Write setup cycles (extended) |
| cfg_wr_datast | input | CNT_W | Write data cycles (extended) |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_bl_n | output | 2 | Byte lane enables, active low |
| mem_addr | output | ADDR_W-1 | Halfword address |
| mem_dq_out | output | 16 | Data bus, outgoing value |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 16 | Data bus, incoming value |

## Verification
The bound checker watches properties that hold on every cycle:
- the read and write strobes are never low together;
- the data bus is driven whenever the write strobe is low, and in the cycle after it rises;
- the address-valid strobe appears only inside a selected, non-write-driving cycle;
- an active access always has a byte lane asserted;
- chip select rises only into the completion cycle;
- `done` is a single pulse.

The exact phase lengths, which strobe variant the configuration chooses, the split address order, lane placement and the assembled read word can only be shown by the bench. Its cycle-by-cycle model predicts every pin across the scenarios in each memory type and extended variant, with zero setup and zero data-phase settings, and with requests and configuration changes arriving while busy.

// File: rtl/asc_pkg.sv
package asc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DATA,
    ST_HOLD,
    ST_GAP
  } phase_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] MT_SRAM  = 2'd0;
  localparam logic [1:0] MT_PSRAM = 2'd1;
  localparam logic [1:0] MT_NOR   = 2'd2;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic adv_en;    // address-valid pulse during setup
    logic oe_early;  // read strobe from start of setup
  } mode_flags_t;

  localparam mode_flags_t MODE_ONE = '{adv_en: 1'b0, oe_early: 1'b1};
  localparam mode_flags_t MODE_TWO = '{adv_en: 1'b1, oe_early: 1'b0};

  function automatic mode_flags_t variant_flags(input logic [1:0] code);
    mode_flags_t f;
    f.adv_en   = (code == 2'd1) || (code == 2'd2);
    f.oe_early = code[1];
    return f;
  endfunction

endpackage

// File: rtl/asc_mode_sel.sv
module asc_mode_sel
  import asc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             ext,
  input  logic [1:0]       mem_type,
  input  logic             is_wr,
  input  logic [1:0]       rd_mode,
  input  logic [1:0]       wr_mode,
  input  logic [CNT_W-1:0] rd_addset,
  input  logic [CNT_W-1:0] rd_datast,
  input  logic [CNT_W-1:0] wr_addset,
  input  logic [CNT_W-1:0] wr_datast,
  output mode_flags_t      flags,
  output logic [CNT_W-1:0] addset,
  output logic [CNT_W-1:0] datast
);

  logic [CNT_W-1:0] ds_raw;

  always_comb begin
    if (ext) begin
      flags  = variant_flags(is_wr ? wr_mode : rd_mode);
      addset = is_wr ? wr_addset : rd_addset;
      ds_raw = is_wr ? wr_datast : rd_datast;
    end else begin
      flags  = (mem_type == MT_NOR) ? MODE_TWO : MODE_ONE;
      addset = rd_addset;
      ds_raw = rd_datast;
    end
    datast = (ds_raw == '0) ? CNT_W'(1) : ds_raw;
  end

endmodule

// File: rtl/asc_lane_gen.sv
module asc_lane_gen
  import asc_pkg::*;
(
  input  logic [1:0]        size,
  input  logic              a0,
  input  logic [WORD_W-1:0] wdata,
  output logic [1:0]        lanes_n,
  output logic [HALF_W-1:0] lo_hw,
  output logic [HALF_W-1:0] hi_hw
);

  always_comb begin
    hi_hw = wdata[WORD_W-1:HALF_W];
    if (size == SZ_BYTE) begin
      lanes_n = a0 ? 2'b01 : 2'b10;
      lo_hw   = {wdata[7:0], wdata[7:0]};
    end else begin
      lanes_n = 2'b00;
      lo_hw   = wdata[HALF_W-1:0];
    end
  end

endmodule

// File: rtl/asc_phase_seq.sv
module asc_phase_seq
  import asc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             split,
  input  logic [CNT_W-1:0] addset,
  input  logic [CNT_W-1:0] datast,
  output phase_t           st,
  output phase_t           st_nxt,
  output logic             half,
  output logic             half_nxt,
  output logic             cap_en
);

  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    st_nxt   = st;
    half_nxt = half;
    cnt_nxt  = cnt;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          half_nxt = 1'b0;
          if (addset != '0) begin
            st_nxt  = ST_SETUP;
            cnt_nxt = addset;
          end else begin
            st_nxt  = ST_DATA;
            cnt_nxt = datast;
          end
        end
      end
      ST_SETUP: begin
        if (cnt <= CNT_W'(1)) begin
          st_nxt  = ST_DATA;
          cnt_nxt = datast;
        end else begin
          cnt_nxt = cnt - CNT_W'(1);
        end
      end
      ST_DATA: begin
        if (cnt <= CNT_W'(1)) st_nxt = ST_HOLD;
        else cnt_nxt = cnt - CNT_W'(1);
      end
      ST_HOLD: begin
        if (split && !half) begin
          half_nxt = 1'b1;
          if (addset != '0) begin
            st_nxt  = ST_SETUP;
            cnt_nxt = addset;
          end else begin
            st_nxt  = ST_DATA;
            cnt_nxt = datast;
          end
        end else begin
          st_nxt = ST_GAP;
        end
      end
      ST_GAP:  st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign cap_en = (st == ST_DATA) && (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      half <= 1'b0;
      cnt  <= '0;
    end else begin
      st   <= st_nxt;
      half <= half_nxt;
      cnt  <= cnt_nxt;
    end
  end

endmodule

// File: rtl/asc_rd_capture.sv
module asc_rd_capture
  import asc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              cap_upper,
  input  logic [HALF_W-1:0] dq_in,
  input  logic              load,
  input  logic [1:0]        size,
  input  logic              a0,
  output logic [WORD_W-1:0] rdata
);

  logic [HALF_W-1:0] lo_q, hi_q;
  logic [WORD_W-1:0] word;

  always_comb begin
    unique case (size)
      SZ_BYTE: word = {24'd0, a0 ? lo_q[15:8] : lo_q[7:0]};
      SZ_HALF: word = {16'd0, lo_q};
      default: word = {hi_q, lo_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      rdata <= '0;
    end else begin
      if (cap_en) begin
        if (cap_upper) hi_q <= dq_in;
        else lo_q <= dq_in;
      end
      if (load) rdata <= word;
    end
  end

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import asc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rdata,
  input  logic              cfg_ext,
  input  logic [1:0]        cfg_mem_type,
  input  logic [1:0]        cfg_rd_mode,
  input  logic [1:0]        cfg_wr_mode,
  input  logic [CNT_W-1:0]  cfg_rd_addset,
  input  logic [CNT_W-1:0]  cfg_rd_datast,
  input  logic [CNT_W-1:0]  cfg_wr_addset,
  input  logic [CNT_W-1:0]  cfg_wr_datast,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [1:0]        mem_bl_n,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);

  localparam int HW_AW = ADDR_W - 1;

  typedef struct packed {
    logic              wr;
    logic [1:0]        size;
    logic              a0;
    logic [HW_AW-1:0]  base;
    logic [HALF_W-1:0] lo_hw;
    logic [HALF_W-1:0] hi_hw;
    logic [1:0]        lanes;
    mode_flags_t       flags;
    logic [CNT_W-1:0]  addset;
    logic [CNT_W-1:0]  datast;
  } ctx_t;

  ctx_t ctx, ctx_nxt, ctx_new;
  phase_t st, st_nxt;
  logic half, half_nxt, cap_en, start;
  logic active_nxt;

  assign start = req_valid && (st == ST_IDLE);

  asc_mode_sel #(.CNT_W(CNT_W)) u_mode (
    .ext       (cfg_ext),
    .mem_type  (cfg_mem_type),
    .is_wr     (req_write),
    .rd_mode   (cfg_rd_mode),
    .wr_mode   (cfg_wr_mode),
    .rd_addset (cfg_rd_addset),
    .rd_datast (cfg_rd_datast),
    .wr_addset (cfg_wr_addset),
    .wr_datast (cfg_wr_datast),
    .flags     (ctx_new.flags),
    .addset    (ctx_new.addset),
    .datast    (ctx_new.datast)
  );

  asc_lane_gen u_lane (
    .size    (req_size),
    .a0      (req_addr[0]),
    .wdata   (req_wdata),
    .lanes_n (ctx_new.lanes),
    .lo_hw   (ctx_new.lo_hw),
    .hi_hw   (ctx_new.hi_hw)
  );

  assign ctx_new.wr   = req_write;
  assign ctx_new.size = req_size;
  assign ctx_new.a0   = req_addr[0];
  assign ctx_new.base = req_addr[ADDR_W-1:1];

  assign ctx_nxt = start ? ctx_new : ctx;

  asc_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .split    (ctx_nxt.size == SZ_WORD),
    .addset   (ctx_nxt.addset),
    .datast   (ctx_nxt.datast),
    .st       (st),
    .st_nxt   (st_nxt),
    .half     (half),
    .half_nxt (half_nxt),
    .cap_en   (cap_en)
  );

  asc_rd_capture u_cap (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .cap_upper (half),
    .dq_in     (mem_dq_in),
    .load      (st_nxt == ST_GAP),
    .size      (ctx.size),
    .a0        (ctx.a0),
    .rdata     (rdata)
  );

  assign active_nxt = (st_nxt == ST_SETUP) || (st_nxt == ST_DATA) || (st_nxt == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx        <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_adv_n  <= 1'b1;
      mem_bl_n   <= 2'b11;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      ctx       <= ctx_nxt;
      busy      <= (st_nxt != ST_IDLE);
      done      <= (st_nxt == ST_GAP);
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_adv_n <= 1'b1;
      mem_bl_n  <= 2'b11;
      mem_dq_oe <= 1'b0;
      unique case (st_nxt)
        ST_SETUP: begin
          mem_ce_n  <= 1'b0;
          mem_oe_n  <= ~(~ctx_nxt.wr & ctx_nxt.flags.oe_early);
          mem_adv_n <= ~ctx_nxt.flags.adv_en;
          mem_bl_n  <= ctx_nxt.lanes;
        end
        ST_DATA: begin
          mem_ce_n  <= 1'b0;
          mem_oe_n  <= ctx_nxt.wr;
          mem_we_n  <= ~ctx_nxt.wr;
          mem_dq_oe <= ctx_nxt.wr;
          mem_bl_n  <= ctx_nxt.lanes;
        end
        ST_HOLD: begin
          mem_ce_n  <= 1'b0;
          mem_dq_oe <= ctx_nxt.wr;
          mem_bl_n  <= ctx_nxt.lanes;
        end
        default: ;
      endcase
      if (active_nxt) begin
        mem_addr   <= ctx_nxt.base + HW_AW'(half_nxt);
        mem_dq_out <= half_nxt ? ctx_nxt.hi_hw : ctx_nxt.lo_hw;
      end
    end
  end

endmodule

// File: rtl/asc_checker.sv
module asc_checker (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       mem_ce_n,
  input logic       mem_oe_n,
  input logic       mem_we_n,
  input logic       mem_adv_n,
  input logic [1:0] mem_bl_n,
  input logic       mem_dq_oe
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mem_ce_n && mem_oe_n && mem_we_n && mem_adv_n && !mem_dq_oe));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  assert_we_drives_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_dq_oe && !mem_ce_n));

  assert_we_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

  assert_oe_no_drive_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_dq_oe && !mem_ce_n));

  assert_oe_rise_in_access_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> !mem_ce_n);

  assert_lane_active_R5: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> (mem_bl_n != 2'b11));

  assert_adv_scope_R8: assert property (@(posedge clk) disable iff (rst)
    !mem_adv_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

  assert_ce_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce_n) |-> done);

  assert_done_gap_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_ce_n && busy));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind async_sram_ctrl asc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_adv_n (mem_adv_n),
  .mem_bl_n  (mem_bl_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_async_sram_ctrl.sv
module tb_async_sram_ctrl;

  localparam int ADDR_W = 20;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]        req_size = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              busy, done;
  logic [31:0]       rdata;
  logic              cfg_ext = 1'b0;
  logic [1:0]        cfg_mem_type = 2'd0, cfg_rd_mode = 2'd0, cfg_wr_mode = 2'd0;
  logic [CNT_W-1:0]  cfg_rd_addset = 4'd2, cfg_rd_datast = 4'd3;
  logic [CNT_W-1:0]  cfg_wr_addset = 4'd1, cfg_wr_datast = 4'd1;
  logic              mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
  logic [1:0]        mem_bl_n;
  logic [ADDR_W-2:0] mem_addr;
  logic [15:0]       mem_dq_out, mem_dq_in;

  async_sram_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .cfg_ext(cfg_ext),
    .cfg_mem_type(cfg_mem_type), .cfg_rd_mode(cfg_rd_mode), .cfg_wr_mode(cfg_wr_mode),
    .cfg_rd_addset(cfg_rd_addset), .cfg_rd_datast(cfg_rd_datast),
    .cfg_wr_addset(cfg_wr_addset), .cfg_wr_datast(cfg_wr_datast),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_adv_n(mem_adv_n), .mem_bl_n(mem_bl_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Behavioural memory on the pins, and a shadow for expected values
  logic [15:0] ram [64];
  logic [15:0] shadow [64];
  logic prev_we = 1'b1;

  function automatic logic [15:0] seed_val(input int i);
    return 16'(i * 16'h0123 + 16'h5A0F);
  endfunction

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? ram[mem_addr[5:0]] : 16'h0BAD;

  always @(negedge clk) begin
    if (!rst && !prev_we && mem_we_n && mem_dq_oe) begin
      if (!mem_bl_n[0]) ram[mem_addr[5:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_bl_n[1]) ram[mem_addr[5:0]][15:8] = mem_dq_out[15:8];
    end
    prev_we <= mem_we_n;
  end

  typedef struct {
    bit ce, oe, we, adv, dqoe, done, busy, chk_rd;
    bit [1:0] bl;
    int addr;
    bit [15:0] dq;
    bit [31:0] rd;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_err = 0;
  bit run_chk = 1'b0;
  string scen = "R1 reset";

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s [%s] t=%0t actual=%h expected=%h", what, scen, $time, act, exp);
    end
  endtask

  function automatic exp_t quiet();
    exp_t e;
    e.ce = 1; e.oe = 1; e.we = 1; e.adv = 1; e.dqoe = 0; e.done = 0; e.busy = 0;
    e.chk_rd = 0; e.bl = 2'b11; e.addr = 0; e.dq = 0; e.rd = 0;
    return e;
  endfunction

  always @(negedge clk) begin
    if (run_chk) begin
      exp_t e;
      e = (q.size() > 0) ? q.pop_front() : quiet();
      chk("R2 mem_ce_n", 32'(mem_ce_n), 32'(e.ce));
      chk("R3 mem_oe_n", 32'(mem_oe_n), 32'(e.oe));
      chk("R4 mem_we_n", 32'(mem_we_n), 32'(e.we));
      chk("R8 mem_adv_n", 32'(mem_adv_n), 32'(e.adv));
      chk("R5 mem_bl_n", 32'(mem_bl_n), 32'(e.bl));
      chk("R4 mem_dq_oe", 32'(mem_dq_oe), 32'(e.dqoe));
      chk("R7 done", 32'(done), 32'(e.done));
      chk("R10 busy", 32'(busy), 32'(e.busy));
      if (!e.ce) chk("R6 mem_addr", 32'(mem_addr), e.addr);
      if (e.dqoe) chk("R4 mem_dq_out", 32'(mem_dq_out), 32'(e.dq));
      if (e.done && e.chk_rd) chk("R7 rdata", rdata, e.rd);
    end
  end

  task automatic push_cyc(input bit oe, input bit we, input bit adv, input bit dqoe,
                          input bit [1:0] bl, input int a, input bit [15:0] dq);
    exp_t e;
    e = quiet();
    e.ce = 0; e.oe = oe; e.we = we; e.adv = adv; e.dqoe = dqoe; e.bl = bl;
    e.addr = a; e.dq = dq; e.busy = 1;
    q.push_back(e);
  endtask

  // Model of one request, from the requirements
  task automatic model_req(input bit wr, input bit [1:0] sz, input int addr, input bit [31:0] wd);
    bit adv_en, early;
    int as, ds, halves, base, ha;
    bit [1:0] bl;
    bit [15:0] hw, lo, hi;
    bit [31:0] rd;
    exp_t e;
    bit [1:0] code;
    if (cfg_ext) begin
      code = wr ? cfg_wr_mode : cfg_rd_mode;
      adv_en = (code == 2'd1) || (code == 2'd2);
      early  = (code == 2'd2) || (code == 2'd3);
      as = wr ? int'(cfg_wr_addset) : int'(cfg_rd_addset);
      ds = wr ? int'(cfg_wr_datast) : int'(cfg_rd_datast);
    end else begin
      adv_en = (cfg_mem_type == 2'd2);
      early  = !adv_en;
      as = int'(cfg_rd_addset);
      ds = int'(cfg_rd_datast);
    end
    if (ds == 0) ds = 1;
    halves = (sz == 2'd2) ? 2 : 1;
    base = addr >> 1;
    bl = (sz == 2'd0) ? ((addr & 1) ? 2'b01 : 2'b10) : 2'b00;
    for (int h = 0; h < halves; h++) begin
      ha = base + h;
      hw = (sz == 2'd0) ? {wd[7:0], wd[7:0]} : (h == 1 ? wd[31:16] : wd[15:0]);
      for (int c = 0; c < as; c++) push_cyc(!(!wr && early), 1, !adv_en, 0, bl, ha, hw);
      for (int c = 0; c < ds; c++) push_cyc(wr, !wr, 1, wr, bl, ha, hw);
      push_cyc(1, 1, 1, wr, bl, ha, hw);
    end
    lo = shadow[base & 63];
    hi = shadow[(base + 1) & 63];
    case (sz)
      2'd0: rd = {24'd0, (addr & 1) ? lo[15:8] : lo[7:0]};
      2'd1: rd = {16'd0, lo};
      default: rd = {hi, lo};
    endcase
    if (wr) begin
      case (sz)
        2'd0: if (addr & 1) shadow[base & 63][15:8] = wd[7:0];
              else shadow[base & 63][7:0] = wd[7:0];
        2'd1: shadow[base & 63] = wd[15:0];
        default: begin
          shadow[base & 63] = wd[15:0];
          shadow[(base + 1) & 63] = wd[31:16];
        end
      endcase
    end
    e = quiet();
    e.done = 1; e.busy = 1; e.rd = rd; e.chk_rd = !wr;
    q.push_back(e);
    q.push_back(quiet());
  endtask

  task automatic issue(input bit wr, input bit [1:0] sz, input int addr, input bit [31:0] wd);
    do begin
      @(negedge clk);
      #1;
    end while (q.size() != 0);
    req_write = wr; req_size = sz; req_addr = ADDR_W'(addr); req_wdata = wd;
    req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    model_req(wr, sz, addr, wd);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R2 actual=hung expected=complete");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      ram[i] = seed_val(i);
      shadow[i] = seed_val(i);
    end
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    run_chk = 1'b1;
    repeat (3) @(posedge clk);

    // R8 mode 1 (SRAM), shared timing, R4 halfword write, R3 read back
    scen = "R8 sram mode1";
    cfg_mem_type = 2'd0; cfg_rd_addset = 4'd2; cfg_rd_datast = 4'd3;
    issue(1, 2'd1, 'h10, 32'h0000_C3A5);
    issue(0, 2'd1, 'h10, 32'h0);
    // R5 byte lanes
    scen = "R5 byte lanes";
    issue(1, 2'd0, 'h21, 32'h0000_0077);
    issue(1, 2'd0, 'h20, 32'h0000_0019);
    issue(0, 2'd1, 'h20, 32'h0);
    issue(0, 2'd0, 'h21, 32'h0);
    issue(0, 2'd0, 'h24, 32'h0);
    // R6 split word
    scen = "R6 split word";
    cfg_mem_type = 2'd1;
    issue(1, 2'd2, 'h30, 32'hBEEF_1234);
    issue(0, 2'd2, 'h30, 32'h0);
    issue(0, 2'd2, 'h3C, 32'h0);
    // R2 zero setup, zero data value
    scen = "R2 zero timing";
    cfg_rd_addset = 4'd0; cfg_rd_datast = 4'd0;
    issue(0, 2'd2, 'h30, 32'h0);
    issue(1, 2'd1, 'h40, 32'h0000_0F0F);
    // R8 NOR mode 2, write timing set unused
    scen = "R8 nor mode2";
    cfg_mem_type = 2'd2; cfg_rd_addset = 4'd3; cfg_rd_datast = 4'd2;
    cfg_wr_addset = 4'd7; cfg_wr_datast = 4'd9;
    issue(1, 2'd1, 'h50, 32'h0000_ABCD);
    issue(0, 2'd1, 'h50, 32'h0);
    // R9 extended, per-direction variants and timing
    scen = "R9 ext C/A";
    cfg_ext = 1'b1; cfg_rd_mode = 2'd2; cfg_wr_mode = 2'd0;
    cfg_rd_addset = 4'd1; cfg_rd_datast = 4'd2; cfg_wr_addset = 4'd3; cfg_wr_datast = 4'd1;
    issue(1, 2'd2, 'h60, 32'h1357_9BDF);
    issue(0, 2'd2, 'h60, 32'h0);
    scen = "R9 ext D/B";
    cfg_rd_mode = 2'd3; cfg_wr_mode = 2'd1; cfg_wr_addset = 4'd2; cfg_wr_datast = 4'd0;
    issue(1, 2'd0, 'h63, 32'h0000_00E1);
    issue(0, 2'd1, 'h62, 32'h0);
    scen = "R9 ext A read";
    cfg_rd_mode = 2'd0;
    issue(0, 2'd0, 'h62, 32'h0);
    // R10 request and config changes while busy
    scen = "R10 busy ignore";
    cfg_rd_addset = 4'd4; cfg_rd_datast = 4'd5;
    issue(0, 2'd2, 'h10, 32'h0);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_addr = 'h7;
    cfg_rd_addset = 4'd0; cfg_rd_datast = 4'd1; cfg_rd_mode = 2'd1; cfg_ext = 1'b0;
    repeat (2) @(posedge clk);
    #1 req_valid = 1'b0;
    cfg_ext = 1'b1; cfg_rd_mode = 2'd0; cfg_rd_addset = 4'd4; cfg_rd_datast = 4'd5;
    issue(0, 2'd1, 'h10, 32'h0);

    do begin
      @(negedge clk);
      #1;
    end while (q.size() != 0);
    repeat (4) @(posedge clk);
    finish_up();
  end

endmodule